// File: doc/BRIEF.md
# Four-Port Serial Management Slave

This block is the management end of a four-port transceiver. It listens to a two-wire serial management bus (clock `mdc`, bidirectional data split into `mdio_i`, `mdio_o` and `mdio_oe`) and answers for four ports. Each port owns its own 32-entry space of 16-bit registers. The port addresses come from three strap pins: the strap value forms the upper address bits, and each port answers one above its base position. Because of that shift, a zero strap never answers at address 0, and a strap of all ones wraps the last port round to address 0.

The block decodes each frame, which is made of a preamble, a start code, an opcode, the port address, the register address, a turnaround and 16 data bits. A read returns the addressed register, most significant bit first. A write updates its writable fields. The register semantics are implemented here:
- a link bit that holds its low value,
- a jabber bit that holds its high value,
- event flags that clear when read,
- a control reset bit that clears itself,
- a saturating receive error counter that clears when read.

All bus inputs are taken into the `clk` domain through a two-stage synchroniser. Management traffic has no valid/ready back-pressure: the bus master sets the pace bit by bit, and the slave keeps up as long as each `mdc` half-period lasts at least four `clk` cycles.

Top module: `mdio_quad_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits sampled on rising `mdc`, then the start pair 0,1, then opcode 1,0 (read) or 0,1 (write). A frame with 31 preamble ones, or with opcode 0,0 or 1,1, gets no drive on `mdio_oe` and changes no register.
- R2: Port p (p = 0..3) answers at the 5-bit address ({phy_strap,2'b00} + p + 1) mod 32. With strap 000 the ports answer at 1 to 4; with strap 111 they answer at 29, 30, 31 and 0. Any other address gets no drive and no write.
- R3: On a matched read, `mdio_oe` stays low for the first turnaround bit. The slave then drives 0 for the second turnaround bit, then the 16 data bits MSB first, each changing after a rising `mdc`. `mdio_oe` drops after the last data bit.
- R4: Register 0 holds the writable fields loopback (bit 14), auto-negotiation enable (bit 12, reset 1) and full duplex (bit 8). They appear on the outputs `loopback`, `aneg_en` and `full_dup` of that port. A write changes only the addressed port.
- R5: Writing 1 to register 0 bit 15 (soft reset) leaves that bit at 1 for exactly one `clk` cycle. In the next cycle the bit and the other register 0 fields return to their reset values, so a read then returns 0x1000.
- R6: Register 1 bit 2 is the latched-low link status. It is 0 after reset. Once it is 0 it stays 0 until register 1 is read, even if `link_up` recovers. A read reloads it from the current `link_up`.
- R7: Register 1 bit 1 is latched-high jabber: it is set by `jabber` and reloaded from `jabber` on a read of register 1. Bit 0 always reads 1 and the other bits read 0.
- R8: Register 17 bits 2:0 are event flags: bit 2 for a falling `link_up`, bit 1 for `rfault_evt`, bit 0 for `aneg_done_evt`. Each is set by its event, cleared by a read of register 17, and cannot be written. An event in the same cycle as the clearing read is kept.
- R9: Register 17 bits 10:8 are writable enables for flags 2:0. `irq[p]` is high while any flag of port p with its enable set is 1.
- R10: Register 21 counts the `clk` cycles with `rx_err` high. It holds at 0xFFFF and clears when read.
- R11: Registers other than 0, 1, 17 and 21, and all bits not named above, read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management bus clock |
| mdio_i | input | 1 | Management data from the bus |
| mdio_o | output | 1 | Management data to the bus |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| phy_strap | input | 3 | Upper port address bits |
| link_up | input | 4 | Per-port live link state |
| jabber | input | 4 | Per-port jabber condition |
| rfault_evt | input | 4 | Per-port remote fault event |
| aneg_done_evt | input | 4 | Per-port auto-negotiation completion event |
| rx_err | input | 4 | Per-port receive error, counted each cycle |
| loopback | output | 4 | Per-port loopback control |
| aneg_en | output | 4 | Per-port auto-negotiation enable |
| full_dup | output | 4 | Per-port full-duplex control |
| irq | output | 4 | Per-port interrupt request |

## Verification
A corrupted frame state shows up on the bus inside the same frame. The slave either drives `mdio_oe` in the wrong bit slot, misses the 0 of the second turnaround bit, or returns data shifted by one position. A read of a known register exposes this within about 64 `mdc` periods. A wrong latch or clear-on-read state appears as a wrong value on the second of two back-to-back reads, and a wrong event or enable state appears on `irq` within a few `clk` cycles of the event. A wrong address map shows as silence, or as an answer from a neighbouring port, on the first access.

// File: rtl/mdio_quad_pkg.sv
package mdio_quad_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_START,
    FS_OPC,
    FS_ADDR,
    FS_TURN,
    FS_DATA
  } fsm_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] RA_EVNT = 5'd17;
  localparam logic [ADDR_W-1:0] RA_ERRC = 5'd21;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_quad_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int SYNC_N  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mdc,
  input  logic                mdio_i,
  input  logic                hit,
  input  logic [WORD_W-1:0]   rd_word,
  output logic [ADDR_W-1:0]   phy_a,
  output logic [ADDR_W-1:0]   reg_a,
  output logic                rd_stb,
  output logic                wr_stb,
  output logic [WORD_W-1:0]   wdata,
  output logic                mdio_o,
  output logic                mdio_oe
);
  localparam int PCW = $clog2(PRE_MIN + 1);
  localparam int IW  = $clog2(WORD_W);

  logic [SYNC_N-1:0]     mdc_sy, dat_sy;
  logic                  mdc_d;
  logic                  rise, bit_s;
  fsm_t                  st;
  logic [PCW-1:0]        pre_cnt;
  logic [IW-1:0]         idx;
  logic                  op_hi, op_rd, ans;
  logic [2*ADDR_W-1:0]   addr_sh;
  logic [WORD_W-1:0]     dsh, tx_sh;

  // bus input synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sy <= '0;
      dat_sy <= '1;
      mdc_d  <= 1'b0;
    end else begin
      mdc_sy <= {mdc_sy[SYNC_N-2:0], mdc};
      dat_sy <= {dat_sy[SYNC_N-2:0], mdio_i};
      mdc_d  <= mdc_sy[SYNC_N-1];
    end
  end

  assign rise  = mdc_sy[SYNC_N-1] & ~mdc_d;
  assign bit_s = dat_sy[SYNC_N-1];
  assign phy_a = addr_sh[2*ADDR_W-1:ADDR_W];
  assign reg_a = addr_sh[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FS_PRE;
      pre_cnt <= '0;
      idx     <= '0;
      op_hi   <= 1'b0;
      op_rd   <= 1'b0;
      ans     <= 1'b0;
      addr_sh <= '0;
      dsh     <= '0;
      tx_sh   <= '0;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      wdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      if (rd_stb) begin
        ans   <= hit;
        tx_sh <= rd_word;
      end
      if (rise) begin
        unique case (st)
          FS_PRE: begin
            if (bit_s) begin
              if (pre_cnt != PCW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PCW'(PRE_MIN)) st <= FS_START;
              pre_cnt <= '0;
            end
          end
          FS_START: begin
            idx <= '0;
            st  <= bit_s ? FS_OPC : FS_PRE;
          end
          FS_OPC: begin
            if (idx == '0) begin
              op_hi <= bit_s;
              idx   <= 1'b1;
            end else begin
              idx <= '0;
              if ({op_hi, bit_s} == OPC_READ) begin
                op_rd <= 1'b1;
                st    <= FS_ADDR;
              end else if ({op_hi, bit_s} == OPC_WRITE) begin
                op_rd <= 1'b0;
                st    <= FS_ADDR;
              end else begin
                st <= FS_PRE;
              end
            end
          end
          FS_ADDR: begin
            addr_sh <= {addr_sh[2*ADDR_W-2:0], bit_s};
            if (idx == IW'(2*ADDR_W-1)) begin
              idx    <= '0;
              st     <= FS_TURN;
              rd_stb <= op_rd;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          FS_TURN: begin
            if (idx == '0) begin
              idx <= 1'b1;
              if (op_rd && ans) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              idx <= '0;
              st  <= FS_DATA;
              if (op_rd && ans) begin
                mdio_o <= tx_sh[WORD_W-1];
                tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
              end
            end
          end
          FS_DATA: begin
            dsh <= {dsh[WORD_W-2:0], bit_s};
            if (idx == IW'(WORD_W-1)) begin
              idx     <= '0;
              st      <= FS_PRE;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
              ans     <= 1'b0;
              if (!op_rd) begin
                wr_stb <= 1'b1;
                wdata  <= {dsh[WORD_W-2:0], bit_s};
              end
            end else begin
              idx <= idx + 1'b1;
              if (mdio_oe) begin
                mdio_o <= tx_sh[WORD_W-1];
                tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
              end
            end
          end
          default: st <= FS_PRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_port_regs.sv
module mdio_port_regs
  import mdio_quad_pkg::*;
#(
  parameter int   CNT_W  = 16,
  parameter logic AN_DEF = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_up,
  input  logic                jabber,
  input  logic                rfault_evt,
  input  logic                aneg_done_evt,
  input  logic                rx_err,
  input  logic                rd_hit,
  input  logic                wr_hit,
  input  logic [ADDR_W-1:0]   reg_a,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                loopback,
  output logic                aneg_en,
  output logic                full_dup,
  output logic                irq,
  output logic                srst_o,
  output logic                lnk_o,
  output logic [CNT_W-1:0]    cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             srst_q, loop_q, anen_q, fdx_q;
  logic             lnk_q, jab_q, link_d;
  logic [2:0]       ien_q, ist_q, ev;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_stat, rd_evnt, rd_errc;
  logic             unused_wd;

  assign rd_stat   = rd_hit && (reg_a == RA_STAT);
  assign rd_evnt   = rd_hit && (reg_a == RA_EVNT);
  assign rd_errc   = rd_hit && (reg_a == RA_ERRC);
  assign ev        = {link_d & ~link_up, rfault_evt, aneg_done_evt};
  assign unused_wd = ^{wdata[13], wdata[11:9], wdata[7:0], wdata[15:11]};

  // control register: writable fields plus self-clearing soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      loop_q <= 1'b0;
      anen_q <= AN_DEF;
      fdx_q  <= 1'b0;
    end else if (srst_q) begin
      srst_q <= 1'b0;
      loop_q <= 1'b0;
      anen_q <= AN_DEF;
      fdx_q  <= 1'b0;
    end else if (wr_hit && (reg_a == RA_CTRL)) begin
      srst_q <= wdata[15];
      loop_q <= wdata[14];
      anen_q <= wdata[12];
      fdx_q  <= wdata[8];
    end
  end

  // status latches, event flags, enables, error counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk_q  <= 1'b0;
      jab_q  <= 1'b0;
      link_d <= 1'b0;
      ien_q  <= '0;
      ist_q  <= '0;
      cnt_q  <= '0;
    end else begin
      link_d <= link_up;
      lnk_q  <= rd_stat ? link_up : (lnk_q & link_up);
      jab_q  <= rd_stat ? jabber  : (jab_q | jabber);
      ist_q  <= (rd_evnt ? 3'b000 : ist_q) | ev;
      if (wr_hit && (reg_a == RA_EVNT)) ien_q <= wdata[10:8];
      if (rd_errc)
        cnt_q <= rx_err ? CNT_W'(1) : '0;
      else if (rx_err && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_a)
      RA_CTRL: rdata = {srst_q, loop_q, 1'b0, anen_q, 3'b000, fdx_q, 8'h00};
      RA_STAT: rdata = {13'h0, lnk_q, jab_q, 1'b1};
      RA_EVNT: rdata = {5'h0, ien_q, 5'h0, ist_q};
      RA_ERRC: rdata = WORD_W'(cnt_q);
      default: rdata = '0;
    endcase
  end

  assign loopback = loop_q;
  assign aneg_en  = anen_q;
  assign full_dup = fdx_q;
  assign irq      = |(ist_q & ien_q);
  assign srst_o   = srst_q;
  assign lnk_o    = lnk_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/mdio_quad_slave.sv
module mdio_quad_slave
  import mdio_quad_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int PRE_MIN = 32,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mdc,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic [2:0]       phy_strap,
  input  logic [NPORT-1:0] link_up,
  input  logic [NPORT-1:0] jabber,
  input  logic [NPORT-1:0] rfault_evt,
  input  logic [NPORT-1:0] aneg_done_evt,
  input  logic [NPORT-1:0] rx_err,
  output logic [NPORT-1:0] loopback,
  output logic [NPORT-1:0] aneg_en,
  output logic [NPORT-1:0] full_dup,
  output logic [NPORT-1:0] irq
);
  localparam int PW = $clog2(NPORT);

  logic [ADDR_W-1:0]      phy_a, reg_a, base_a;
  logic                   rd_stb, wr_stb, hit;
  logic [WORD_W-1:0]      wdata, rd_word;
  logic [NPORT-1:0]       sel, srst_vec, lnk_vec;
  logic [WORD_W-1:0]      prt_rd [NPORT];
  logic [NPORT*CNT_W-1:0] cnt_flat;

  assign base_a = {phy_strap, {PW{1'b0}}};
  assign hit    = |sel;

  mdio_frame_fsm #(.PRE_MIN(PRE_MIN), .SYNC_N(2)) frame_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_i  (mdio_i),
    .hit     (hit),
    .rd_word (rd_word),
    .phy_a   (phy_a),
    .reg_a   (reg_a),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .wdata   (wdata),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [ADDR_W-1:0] my_a;
    assign my_a   = base_a + ADDR_W'(p + 1);
    assign sel[p] = (phy_a == my_a);

    mdio_port_regs #(.CNT_W(CNT_W), .AN_DEF(1'b1)) regs_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .link_up       (link_up[p]),
      .jabber        (jabber[p]),
      .rfault_evt    (rfault_evt[p]),
      .aneg_done_evt (aneg_done_evt[p]),
      .rx_err        (rx_err[p]),
      .rd_hit        (rd_stb & sel[p]),
      .wr_hit        (wr_stb & sel[p]),
      .reg_a         (reg_a),
      .wdata         (wdata),
      .rdata         (prt_rd[p]),
      .loopback      (loopback[p]),
      .aneg_en       (aneg_en[p]),
      .full_dup      (full_dup[p]),
      .irq           (irq[p]),
      .srst_o        (srst_vec[p]),
      .lnk_o         (lnk_vec[p]),
      .cnt_o         (cnt_flat[p*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPORT; p++)
      if (sel[p]) rd_word = rd_word | prt_rd[p];
  end
endmodule

// File: rtl/mdio_quad_slave_chk.sv
module mdio_quad_slave_chk #(
  parameter int NPORT = 4,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mdio_o,
  input logic                   mdio_oe,
  input logic                   rd_stb,
  input logic                   wr_stb,
  input logic [NPORT-1:0]       sel,
  input logic [NPORT-1:0]       srst_vec,
  input logic [NPORT-1:0]       lnk_vec,
  input logic [NPORT-1:0]       link_up,
  input logic [NPORT*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2

  AST_TURN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R3

  AST_NO_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !mdio_oe); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R1

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      srst_vec[p] |=> !srst_vec[p]); // R5

    AST_LINK_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up[p] |=> !lnk_vec[p]); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[p*CNT_W +: CNT_W] == CNT_MAX) |=>
        ((cnt_flat[p*CNT_W +: CNT_W] == CNT_MAX) ||
         (cnt_flat[p*CNT_W +: CNT_W] <= CNT_W'(1)))); // R10
  end
endmodule

bind mdio_quad_slave mdio_quad_slave_chk #(.NPORT(NPORT), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .sel      (sel),
  .srst_vec (srst_vec),
  .lnk_vec  (lnk_vec),
  .link_up  (link_up),
  .cnt_flat (cnt_flat)
);

// File: tb/mdio_quad_slave_tb_top.sv
module mdio_quad_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdc = 1'b0;
  logic       mdio_i = 1'b1;
  logic       mdio_o, mdio_oe;
  logic [2:0] phy_strap = 3'b000;
  logic [3:0] link_up = 4'hF, jabber = '0, rfault_evt = '0, aneg_done_evt = '0, rx_err = '0;
  logic [3:0] loopback, aneg_en, full_dup, irq;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mdio_quad_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_strap(phy_strap), .link_up(link_up), .jabber(jabber),
    .rfault_evt(rfault_evt), .aneg_done_evt(aneg_done_evt), .rx_err(rx_err),
    .loopback(loopback), .aneg_en(aneg_en), .full_dup(full_dup), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      logic [15:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, 32'(a), 32'(e));
    end
  end

  task automatic mbit(input logic b, output logic line, output logic oe);
    @(negedge clk);
    mdc = 1'b0;
    mdio_i = b;
    repeat (4) @(negedge clk);
    mdc = 1'b1;
    oe = mdio_oe;
    line = mdio_oe ? mdio_o : b;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic ta_ok, output logic drove);
    logic l, o;
    logic [13:0] hdr;
    hdr = {2'b01, op, phy, ra};
    rd = '0; ta_ok = 1'b1; drove = 1'b0;
    for (int i = 0; i < npre; i++) begin mbit(1'b1, l, o); drove |= o; end
    for (int i = 13; i >= 0; i--) begin mbit(hdr[i], l, o); drove |= o; end
    if (op == 2'b10) begin
      mbit(1'b1, l, o); drove |= o; ta_ok &= !o;
      mbit(1'b1, l, o); drove |= o; ta_ok &= (o && !l);
      for (int i = 0; i < 16; i++) begin mbit(1'b1, l, o); drove |= o; rd = {rd[14:0], l}; end
    end else begin
      mbit(1'b1, l, o); drove |= o;
      mbit(1'b0, l, o); drove |= o;
      for (int i = 15; i >= 0; i--) begin mbit(wd[i], l, o); drove |= o; end
    end
    @(negedge clk);
    mdc = 1'b0;
    mdio_i = 1'b1;
    repeat (10) @(negedge clk);
    ta_ok &= !mdio_oe;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] r; logic t, d;
    frame(32, 2'b01, phy, ra, wd, r, t, d);
  endtask

  // driver: expected value into the scoreboard, actual from the bus
  task automatic rd_expect(input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] expv, input string tag);
    logic [15:0] r; logic t, d;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    frame(32, 2'b10, phy, ra, 16'h0, r, t, d);
    act_q.push_back(r);
    chk(t, "R3 turnaround/release", 32'(t), 32'd1);
  endtask

  task automatic rd_silent(input int npre, input logic [1:0] op, input logic [4:0] phy, input string tag);
    logic [15:0] r; logic t, d;
    frame(npre, op, phy, 5'd0, 16'h0, r, t, d);
    chk(!d, tag, 32'(d), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // reset state
    chk(mdio_oe == 1'b0, "R3 reset oe", 32'(mdio_oe), 32'd0);
    chk({loopback, aneg_en, full_dup, irq} == 16'h0F00, "R4 reset outputs",
        32'({loopback, aneg_en, full_dup, irq}), 32'h0F00);

    // R6/R7: latched-low link starts 0, reload on read
    rd_expect(5'd1, 5'd1, 16'h0001, "R6 first read");
    rd_expect(5'd1, 5'd1, 16'h0005, "R6 reloaded");
    @(negedge clk); link_up[0] = 1'b0;
    repeat (20) @(negedge clk); link_up[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd_expect(5'd1, 5'd1, 16'h0001, "R6 held low");
    rd_expect(5'd1, 5'd1, 16'h0005, "R6 after read");

    // R8 event flags
    rd_expect(5'd1, 5'd17, 16'h0004, "R8 link fall flag");
    rd_expect(5'd1, 5'd17, 16'h0000, "R8 cleared");
    @(negedge clk); rfault_evt[1] = 1'b1; aneg_done_evt[1] = 1'b1;
    @(negedge clk); rfault_evt[1] = 1'b0; aneg_done_evt[1] = 1'b0;
    rd_expect(5'd2, 5'd17, 16'h0003, "R8 rf+an flags");
    rd_expect(5'd2, 5'd17, 16'h0000, "R8 cleared again");

    // R9 enables and irq
    wr(5'd2, 5'd17, 16'h0100);
    chk(irq == 4'h0, "R9 irq idle", 32'(irq), 32'h0);
    @(negedge clk); rfault_evt[1] = 1'b1;
    @(negedge clk); rfault_evt[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 4'h0, "R9 masked event", 32'(irq), 32'h0);
    @(negedge clk); aneg_done_evt[1] = 1'b1;
    @(negedge clk); aneg_done_evt[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 4'h2, "R9 enabled event", 32'(irq), 32'h2);
    rd_expect(5'd2, 5'd17, 16'h0103, "R9 enable readback");
    chk(irq == 4'h0, "R9 irq cleared", 32'(irq), 32'h0);

    // R4 writes
    wr(5'd3, 5'd0, 16'h4100);
    chk({loopback, aneg_en, full_dup} == 12'h4B4, "R4 outputs",
        32'({loopback, aneg_en, full_dup}), 32'h4B4);
    rd_expect(5'd3, 5'd0, 16'h4100, "R4 readback");
    rd_expect(5'd4, 5'd0, 16'h1000, "R4 other port untouched");

    // R5 soft reset
    wr(5'd3, 5'd0, 16'hC100);
    rd_expect(5'd3, 5'd0, 16'h1000, "R5 self clear");
    chk({loopback, aneg_en, full_dup} == 12'h0F0, "R5 defaults",
        32'({loopback, aneg_en, full_dup}), 32'h0F0);

    // R11 reserved
    wr(5'd4, 5'd5, 16'hFFFF);
    rd_expect(5'd4, 5'd5, 16'h0000, "R11 unmapped reg");
    wr(5'd4, 5'd1, 16'hFFFF);
    rd_expect(5'd4, 5'd1, 16'h0001, "R11 status unwritable");
    wr(5'd4, 5'd0, 16'h2EFF);
    rd_expect(5'd4, 5'd0, 16'h0000, "R11 ctrl reserved bits");
    chk(aneg_en == 4'h7, "R11 aneg cleared", 32'(aneg_en), 32'h7);
    wr(5'd4, 5'd17, 16'hF8FF);
    rd_expect(5'd4, 5'd17, 16'h0000, "R11 flags unwritable");

    // R7 jabber
    @(negedge clk); jabber[2] = 1'b1;
    @(negedge clk); jabber[2] = 1'b0;
    rd_expect(5'd3, 5'd1, 16'h0003, "R7 jabber latched");
    rd_expect(5'd3, 5'd1, 16'h0005, "R7 jabber reloaded");

    // R1 frame validity
    begin
      logic [15:0] r; logic t, d;
      frame(31, 2'b01, 5'd4, 5'd0, 16'h4100, r, t, d);
    end
    rd_expect(5'd4, 5'd0, 16'h0000, "R1 short preamble write ignored");
    rd_silent(31, 2'b10, 5'd4, "R1 short preamble read");
    rd_silent(32, 2'b00, 5'd4, "R1 bad opcode 00");
    begin
      logic [15:0] r; logic t, d;
      frame(32, 2'b11, 5'd4, 5'd0, 16'h4100, r, t, d);
    end
    rd_expect(5'd4, 5'd0, 16'h0000, "R1 opcode 11 write ignored");

    // R2 address map
    rd_silent(32, 2'b10, 5'd5, "R2 addr 5 silent");
    rd_silent(32, 2'b10, 5'd0, "R2 addr 0 silent strap 000");
    phy_strap = 3'b111;
    repeat (5) @(negedge clk);
    rd_expect(5'd29, 5'd0, 16'h1000, "R2 port0 at 29");
    rd_expect(5'd0, 5'd0, 16'h0000, "R2 port3 at 0");
    wr(5'd31, 5'd0, 16'h4000);
    chk(loopback == 4'h4, "R2 write via 31", 32'(loopback), 32'h4);
    rd_silent(32, 2'b10, 5'd1, "R2 addr 1 silent strap 111");

    // R10 error counter
    @(negedge clk); rx_err[0] = 1'b1;
    repeat (10) @(negedge clk); rx_err[0] = 1'b0;
    rd_expect(5'd29, 5'd21, 16'd10, "R10 count");
    rd_expect(5'd29, 5'd21, 16'd0, "R10 clear on read");
    @(negedge clk); rx_err[1] = 1'b1;
    repeat (65540) @(negedge clk); rx_err[1] = 1'b0;
    rd_expect(5'd30, 5'd21, 16'hFFFF, "R10 saturate");
    rd_expect(5'd30, 5'd21, 16'h0000, "R10 clear after saturate");

    repeat (5) @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule